// File: doc/BRIEF.md
# Packet User-Defined Field Extractor

This block takes an Ethernet frame as a byte stream and lifts out up to nine 16-bit words for a later match stage. Each word comes from a position given by a one-byte slot setting. The setting names an anchor in the frame (the first byte, the end of the layer-2 header or the end of the layer-3 header) and a distance from that anchor counted in 16-bit words. An upstream parser supplies the two header-end byte positions as input hints. They must be held steady from the frame's first byte to its last.

When a frame ends, the block presents every extracted word, a per-slot valid vector and a one-cycle done strobe. The words and the vector then stay unchanged until the next frame ends. A typical IPv4 TCP/UDP setup uses six slots. Four of them take the address halves at layer-2 word offsets 6 to 9, and two take the port numbers at layer-3 word offsets 0 and 1.

Top module: `udf_extract`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_wdata` into the slot named by `cfg_slot` at the next clock edge. Reset clears every slot to 0x00. A write to a slot index of `NUM_SLOTS` or more changes no slot.
- R2: A slot whose setting is 0x00, or whose anchor field (bits [6:5]) is 1, is unused. Its valid bit is 0 and its word reads 0x0000.
- R3: Anchor 0 counts from the frame's first byte, which is position 0. Word offset k (bits [4:0]) selects bytes 2k and 2k+1. Bit 7 is ignored apart from making the setting nonzero, so 0x80 selects bytes 0 and 1.
- R4: Anchor 2 selects bytes `l2_end`+2k and `l2_end`+2k+1. The hint is taken as it stands while the frame is received.
- R5: Anchor 3 selects bytes `l3_end`+2k and `l3_end`+2k+1.
- R6: Words are big-endian: the earlier byte of the pair sits in bits [15:8].
- R7: If the second byte of a slot's pair lies at or beyond the frame length, that slot is reported not valid with a word of 0x0000. This also covers a pair of which only the first byte arrived.
- R8: Bit i of `field_valid_o` belongs to slot i, and slot i's word is `field_data_o[16*i+15:16*i]`. When slots 0 to N-1 are used and in range and the rest are unused, the vector equals the low N bits set.
- R9: `done_o` is high for exactly the one cycle after the edge that takes the frame's last byte. The words and the valid vector change only at that edge and are otherwise held, including while the next frame is arriving.
- R10: Cycles with `in_valid` low do not advance the byte position. Beats outside a frame (after an end marker and before the next start marker) are ignored, including ones that carry an end marker.
- R11: A start marker always restarts the position at 0. A frame cut short by a new start marker produces no result, and extraction follows the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Slot setting write enable |
| cfg_slot | input | SLOT_W | Slot index to write |
| cfg_wdata | input | 8 | Slot setting: [6:5] anchor, [4:0] word offset |
| in_valid | input | 1 | A frame byte is present this cycle |
| in_sof | input | 1 | This byte is the first of a frame |
| in_eof | input | 1 | This byte is the last of a frame |
| in_byte | input | 8 | Frame byte |
| l2_end | input | POS_W | Byte position where the layer-2 header ends |
| l3_end | input | POS_W | Byte position where the layer-3 header ends |
| field_data_o | output | 16*NUM_SLOTS | Extracted words, slot i in bits [16i+15:16i] |
| field_valid_o | output | NUM_SLOTS | Per-slot valid vector |
| done_o | output | 1 | One-cycle strobe after a frame's last byte |

## Verification
The bench fills frames with a position-dependent byte pattern, so any word taken from the wrong byte pair, or with its two bytes swapped, shows up as a wrong value. An IPv4-style slot set is run under two sets of layer-2 and layer-3 hints, which separates the anchors from one another and shows whether the hints are followed. Settings placed near the frame's end are run against frame lengths one byte either side of the limit, which tells a complete pair apart from a half or missing pair. Streams with idle gaps, stray beats outside a frame, writes to nonexistent slots and frames cut short by a new start marker show whether the position and the results react only to the beats that count.

// File: rtl/udf_pkg.sv
package udf_pkg;
   localparam int CFG_W  = 8;
   localparam int OFS_W  = 5;
   localparam int WORD_W = 16;

   typedef enum logic [1:0] {
      ANC_FRAME = 2'd0,
      ANC_RSVD  = 2'd1,
      ANC_L2    = 2'd2,
      ANC_L3    = 2'd3
   } anchor_e;

   function automatic anchor_e cfg_anchor(input logic [CFG_W-1:0] c);
      return anchor_e'(c[6:5]);
   endfunction

   function automatic logic slot_used(input logic [CFG_W-1:0] c);
      return (c != '0) && (cfg_anchor(c) != ANC_RSVD);
   endfunction
endpackage

// File: rtl/udf_cfg_file.sv
module udf_cfg_file
   import udf_pkg::*;
#(
   parameter int NUM_SLOTS = 9,
   parameter int SLOT_W    = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              we,
   input  logic [SLOT_W-1:0]                 slot,
   input  logic [CFG_W-1:0]                  wdata,
   output logic [NUM_SLOTS-1:0][CFG_W-1:0]   cfg_o
);
   logic [NUM_SLOTS-1:0][CFG_W-1:0] cfg_q;

   generate
      if (NUM_SLOTS > (1 << SLOT_W)) begin : g_bad_width
         $error("udf_cfg_file: SLOT_W too narrow for NUM_SLOTS");
      end
      for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cfg_q[g] <= '0;
            else if (we && (slot == SLOT_W'(g)))
               cfg_q[g] <= wdata;
         end
      end
   endgenerate

   assign cfg_o = cfg_q;

   assert_bad_slot_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (32'(slot) >= 32'(NUM_SLOTS))) |=> $stable(cfg_q));
endmodule

// File: rtl/udf_pos_track.sv
module udf_pos_track #(
   parameter int POS_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic             in_eof,
   output logic             beat_o,
   output logic             first_o,
   output logic             last_o,
   output logic [POS_W-1:0] pos_o
);
   localparam logic [POS_W-1:0] POS_MAX = '1;

   logic             in_frame_q;
   logic [POS_W-1:0] cnt_q;

   assign beat_o  = in_valid && (in_sof || in_frame_q);
   assign first_o = beat_o && in_sof;
   assign last_o  = beat_o && in_eof;
   assign pos_o   = in_sof ? '0 : cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         cnt_q      <= '0;
      end else if (beat_o) begin
         in_frame_q <= !in_eof;
         cnt_q      <= (pos_o == POS_MAX) ? POS_MAX : pos_o + 1'b1;
      end
   end

   assert_sof_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof) |=> (cnt_q == POS_W'(1)));
   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(cnt_q));
endmodule

// File: rtl/udf_slot.sv
module udf_slot
   import udf_pkg::*;
#(
   parameter int POS_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CFG_W-1:0]  cfg,
   input  logic [POS_W-1:0]  l2_end,
   input  logic [POS_W-1:0]  l3_end,
   input  logic              beat,
   input  logic              first,
   input  logic              last,
   input  logic [POS_W-1:0]  pos,
   input  logic [7:0]        byte_in,
   output logic [WORD_W-1:0] data_o,
   output logic              valid_o
);
   localparam int EXT_W = POS_W + 2;

   logic [POS_W-1:0] base;
   logic [EXT_W-1:0] hi_at, lo_at, pos_ext;
   logic [7:0]       hi_q, lo_q, hi_n, lo_n;
   logic             got_hi_q, got_lo_q, got_hi_n, got_lo_n, ok_n;

   always_comb begin
      unique case (cfg_anchor(cfg))
         ANC_L2:  base = l2_end;
         ANC_L3:  base = l3_end;
         default: base = '0;
      endcase
   end

   assign hi_at   = EXT_W'(base) + EXT_W'({cfg[OFS_W-1:0], 1'b0});
   assign lo_at   = hi_at + 1'b1;
   assign pos_ext = EXT_W'(pos);

   always_comb begin
      hi_n     = hi_q;
      lo_n     = lo_q;
      got_hi_n = first ? 1'b0 : got_hi_q;
      got_lo_n = first ? 1'b0 : got_lo_q;
      if (beat && (pos_ext == hi_at)) begin
         hi_n     = byte_in;
         got_hi_n = 1'b1;
      end
      if (beat && (pos_ext == lo_at)) begin
         lo_n     = byte_in;
         got_lo_n = 1'b1;
      end
      ok_n = slot_used(cfg) && got_hi_n && got_lo_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q     <= '0;
         lo_q     <= '0;
         got_hi_q <= 1'b0;
         got_lo_q <= 1'b0;
         data_o   <= '0;
         valid_o  <= 1'b0;
      end else if (beat) begin
         hi_q     <= hi_n;
         lo_q     <= lo_n;
         got_hi_q <= got_hi_n;
         got_lo_q <= got_lo_n;
         if (last) begin
            valid_o <= ok_n;
            data_o  <= ok_n ? {hi_n, lo_n} : '0;
         end
      end
   end

   assert_invalid_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> (data_o == '0));
endmodule

// File: rtl/udf_extract.sv
module udf_extract
   import udf_pkg::*;
#(
   parameter int  NUM_SLOTS = 9,
   parameter int  POS_W     = 11,
   localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_we,
   input  logic [SLOT_W-1:0]           cfg_slot,
   input  logic [7:0]                  cfg_wdata,
   input  logic                        in_valid,
   input  logic                        in_sof,
   input  logic                        in_eof,
   input  logic [7:0]                  in_byte,
   input  logic [POS_W-1:0]            l2_end,
   input  logic [POS_W-1:0]            l3_end,
   output logic [WORD_W*NUM_SLOTS-1:0] field_data_o,
   output logic [NUM_SLOTS-1:0]        field_valid_o,
   output logic                        done_o
);
   generate
      if (NUM_SLOTS < 1 || NUM_SLOTS > 32) begin : g_bad_slots
         $error("udf_extract: NUM_SLOTS must be 1..32");
      end
      if (POS_W < 7) begin : g_bad_pos
         $error("udf_extract: POS_W must cover the largest start-of-frame offset");
      end
   endgenerate

   logic [NUM_SLOTS-1:0][CFG_W-1:0] cfg;
   logic             beat, first, last;
   logic [POS_W-1:0] pos;

   udf_cfg_file #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .slot(cfg_slot),
      .wdata(cfg_wdata), .cfg_o(cfg)
   );

   udf_pos_track #(.POS_W(POS_W)) u_pos (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_eof(in_eof), .beat_o(beat), .first_o(first), .last_o(last),
      .pos_o(pos)
   );

   generate
      for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_field
         udf_slot #(.POS_W(POS_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .cfg(cfg[g]),
            .l2_end(l2_end), .l3_end(l3_end),
            .beat(beat), .first(first), .last(last), .pos(pos),
            .byte_in(in_byte),
            .data_o(field_data_o[g*WORD_W +: WORD_W]),
            .valid_o(field_valid_o[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_o <= 1'b0;
      else        done_o <= last;
   end

   assert_done_after_eof_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(in_valid && in_eof));
   assert_results_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(field_data_o) && $stable(field_valid_o)));
endmodule

// File: tb/udf_extract_tb.sv
`timescale 1ns/100ps
module udf_extract_tb;
   localparam int NS  = 9;
   localparam int PW  = 11;
   localparam int SW  = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic [SW-1:0]    cfg_slot = '0;
   logic [7:0]       cfg_wdata = '0;
   logic             in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
   logic [7:0]       in_byte = '0;
   logic [PW-1:0]    l2_end = '0, l3_end = '0;
   logic [16*NS-1:0] field_data_o;
   logic [NS-1:0]    field_valid_o;
   logic             done_o;

   int total = 0;
   int bad   = 0;
   logic [7:0]  cfg_sh  [NS];
   logic [15:0] exp_dat [NS];
   logic        exp_vld [NS];

   always #2.5 clk = ~clk;

   udf_extract #(.NUM_SLOTS(NS), .POS_W(PW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
      .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_sof(in_sof),
      .in_eof(in_eof), .in_byte(in_byte), .l2_end(l2_end), .l3_end(l3_end),
      .field_data_o(field_data_o), .field_valid_o(field_valid_o),
      .done_o(done_o)
   );

   function automatic logic [7:0] fbyte(input int i, input int seed);
      return 8'((i * 29) + (seed * 11) + 3 + (i >> 3));
   endfunction

   task automatic chk(input logic ok, input string req, input logic [31:0] act,
                      input logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   task automatic check_all(input string req);
      for (int i = 0; i < NS; i++) begin
         chk(field_valid_o[i] == exp_vld[i], req, 32'(field_valid_o[i]), 32'(exp_vld[i]));
         chk(field_data_o[i*16 +: 16] == exp_dat[i], req,
             32'(field_data_o[i*16 +: 16]), 32'(exp_dat[i]));
      end
   endtask

   task automatic set_cfg(input int s, input logic [7:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_slot = SW'(s); cfg_wdata = v;
      if (s < NS) cfg_sh[s] = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_all(input logic [7:0] v [NS]);
      for (int i = 0; i < NS; i++) set_cfg(i, v[i]);
   endtask

   // expected results derived from R2..R7
   task automatic model(input int len, input int seed);
      for (int i = 0; i < NS; i++) begin
         int base, s;
         logic [7:0] c;
         c = cfg_sh[i];
         base = (c[6:5] == 2'd2) ? int'(l2_end) : (c[6:5] == 2'd3) ? int'(l3_end) : 0;
         s = base + 2 * int'(c[4:0]);
         if (c == 8'h00 || c[6:5] == 2'd1 || (s + 1) >= len) begin
            exp_vld[i] = 1'b0; exp_dat[i] = 16'h0000;
         end else begin
            exp_vld[i] = 1'b1; exp_dat[i] = {fbyte(s, seed), fbyte(s + 1, seed)};
         end
      end
   endtask

   task automatic beat(input logic [7:0] b, input logic s, input logic e);
      @(negedge clk);
      in_valid = 1'b1; in_byte = b; in_sof = s; in_eof = e;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      end
   endtask

   task automatic send_frame(input int len, input int seed, input int gap, input string req);
      model(len, seed);
      for (int i = 0; i < len; i++) begin
         beat(fbyte(i, seed), i == 0, i == len - 1);
         if (gap > 0 && i < len - 1) idle(gap);
      end
      idle(1);
      chk(done_o == 1'b1, "R9 done after last byte", 32'(done_o), 32'd1);
      check_all(req);
      idle(1);
      chk(done_o == 1'b0, "R9 done one cycle", 32'(done_o), 32'd0);
      check_all("R9 held after done");
   endtask

   task automatic t_reset;
      chk(done_o == 1'b0, "R9 reset done", 32'(done_o), 32'd0);
      chk(field_valid_o == '0, "R1 reset valid", 32'(field_valid_o), 32'd0);
      chk(field_data_o == '0, "R1 reset data", 32'(field_data_o[31:0]), 32'd0);
      for (int i = 0; i < NS; i++) cfg_sh[i] = 8'h00;
      send_frame(40, 1, 0, "R1 R2 reset settings unused");
   endtask

   task automatic t_ipv4;
      logic [7:0] v [NS] = '{8'h46, 8'h47, 8'h48, 8'h49, 8'h60, 8'h61, 8'h00, 8'h00, 8'h00};
      set_all(v);
      l2_end = 11'd14; l3_end = 11'd34;
      send_frame(60, 2, 0, "R4 R5 R6 IPv4 layout");
      chk(field_valid_o == 9'h03F, "R8 low six bits", 32'(field_valid_o), 32'h3F);
      l2_end = 11'd18; l3_end = 11'd42;
      send_frame(64, 3, 0, "R4 R5 moved hints");
      chk(field_valid_o == 9'h03F, "R8 low six bits again", 32'(field_valid_o), 32'h3F);
   endtask

   task automatic t_sof_edges;
      logic [7:0] v [NS] = '{8'h80, 8'h03, 8'h1F, 8'h25, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      set_all(v);
      send_frame(64, 4, 0, "R3 start anchor in range");
      chk(field_data_o[15:0] == {fbyte(0, 4), fbyte(1, 4)}, "R6 R3 bytes 0-1 order",
          32'(field_data_o[15:0]), 32'({fbyte(0, 4), fbyte(1, 4)}));
      chk(field_valid_o == 9'h007, "R2 reserved anchor unused", 32'(field_valid_o), 32'h7);
      send_frame(63, 5, 0, "R7 half pair at end");
      chk(field_valid_o[2] == 1'b0, "R7 slot 2 dropped", 32'(field_valid_o[2]), 32'd0);
      send_frame(20, 6, 0, "R7 pair beyond end");
   endtask

   task automatic t_gaps_stray;
      send_frame(40, 7, 2, "R10 idle gaps");
      beat(8'hAA, 1'b0, 1'b0);
      beat(8'h55, 1'b0, 1'b1);
      idle(1);
      chk(done_o == 1'b0, "R10 stray end marker", 32'(done_o), 32'd0);
      check_all("R10 stray beats ignored");
      send_frame(40, 8, 0, "R10 frame after stray beats");
   endtask

   task automatic t_bad_slot;
      set_cfg(9, 8'h81);
      set_cfg(15, 8'h40);
      set_cfg(12, 8'h80);
      send_frame(64, 9, 0, "R1 out of range write ignored");
      chk(field_valid_o == 9'h007, "R1 R8 vector unchanged", 32'(field_valid_o), 32'h7);
   endtask

   task automatic t_restart;
      logic [15:0] held [NS];
      logic        hv   [NS];
      for (int i = 0; i < NS; i++) begin held[i] = exp_dat[i]; hv[i] = exp_vld[i]; end
      for (int i = 0; i < 12; i++) beat(fbyte(i, 10), i == 0, 1'b0);
      idle(1);
      chk(done_o == 1'b0, "R9 no done mid-frame", 32'(done_o), 32'd0);
      for (int i = 0; i < NS; i++) begin exp_dat[i] = held[i]; exp_vld[i] = hv[i]; end
      check_all("R9 held while next frame arrives");
      send_frame(64, 11, 0, "R11 restart on start marker");
      for (int i = 0; i < 5; i++) beat(fbyte(i, 12), i == 0, 1'b0);
      send_frame(30, 13, 1, "R11 cut frame then short frame");
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_ipv4;
      t_sof_edges;
      t_gaps_stray;
      t_bad_slot;
      t_restart;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule